// File: doc/BRIEF.md
# Isochronous Transmit Timestamp Inserter

This block sits in the transmit path of a serial-bus link layer, between the engine that fetches stream words and the packet serializer. Each outgoing isochronous packet arrives one 32-bit word per handshake, with a transmit-context number and a last-word marker beside it. The block tracks where it is inside the packet and rewrites timestamps on the fly. Every word, changed or not, leaves exactly one register stage later.

Two stream kinds are handled. For digital-video streams it builds a presentation timestamp from the running bus cycle timer plus the context's offset register. It places that timestamp in the SYT field of the second CIP quadlet, but only on packets flagged as the start of a video frame. For MPEG2 transport streams it rewrites the cycle fields of every source-packet timestamp. It adds the context's user offset and also an initial delta, which it learns from the first transport packet of the stream. A per-context bit turns the delta off.

A small write-only register bus sets and clears the control bits and loads the eight offset registers. The packet walker is a four-state machine. ST_HEAD takes the isochronous header. ST_CIP0 and ST_CIP1 take the two CIP quadlets. ST_BODY takes the payload. Each accepted word advances ST_HEAD→ST_CIP0→ST_CIP1→ST_BODY, ST_BODY stays in ST_BODY, and an accepted word marked last returns any state to ST_HEAD.

Top module: `iso_ts_inserter`

## Requirements
- R1: A register write to word address 0 ORs the write data into the control register. A write to word address 1 clears every control bit that is 1 in the write data. Either change takes effect from the next cycle.
- R2: Every accepted input word appears on the output exactly one cycle after acceptance, with its context and last marker. The block can accept whenever its output stage is empty or being drained. While the output is stalled, the output word holds steady.
- R3: A packet gets the video timestamp when control bit 8 is set, its header tag (header bits 15:14) is 2'b01, the FMT field of the second CIP quadlet (bits 29:24) is 6'h00, and the frame flag was high with its header word. Bits 15:0 of that quadlet are then replaced by {count[3:0], offset[11:0]}. Here count:offset is the bus cycle timer plus bits 24:12 (count) and 11:0 (offset) of the context's offset register. The offset sum wraps at 3072 with a carry into the count, and the count wraps at 8000.
- R4: A video packet without the frame flag, with another tag, or sent while bit 8 is clear, leaves the SYT field unchanged.
- R5: A packet gets transport-stream adjustment when control bit 10 is set (sampled at the second CIP quadlet), its tag is 2'b01, and its FMT is 6'h20. The source-packet header is every 48th payload word, starting at the first. Only its bits 24:0 (count 24:12, offset 11:0) are rewritten.
- R6: On the first source-packet header of a context with no stored delta, the block stores delta = (bus cycle count − header count) mod 8000. That header and every later one on the context get header + user offset + delta cycles, with the same wrap rules as R3.
- R7: When bit 31 of the context's offset register is 1, no delta is stored or added. Only the user offset is added.
- R8: The stored deltas of all contexts are discarded the cycle after control bit 10 goes from 0 to 1. A context's delta is discarded when a restart pulse names that context. Either way, the next source-packet header recaptures it.
- R9: Words of packets that qualify for neither adjustment pass unchanged. Bits 31:25 of every word pass unchanged.
- R10: Offset registers sit at word addresses 8 to 15, one per context 0 to 7. Each context uses only its own register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_count | input | 13 | Bus cycle timer, cycle count (0..7999) |
| cyc_offset | input | 12 | Bus cycle timer, cycle offset (0..3071) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| restart | input | 1 | Context restart pulse |
| restart_ctx | input | 3 | Context being restarted |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input packet word |
| in_ctx | input | 3 | Transmit context of the packet |
| in_last | input | 1 | Last word of the packet |
| in_frame | input | 1 | With the header word: packet starts a video frame |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Output packet word |
| out_ctx | output | 3 | Transmit context of the output word |
| out_last | output | 1 | Last word of the packet |

## Verification
Each output word is due one cycle after its input word is accepted. The bench checks out_valid at the falling edge after every acceptance. It compares words against its model queue only when a transfer happens, so stalls shift results in time without changing them. A register write becomes active one cycle after its strobe, and an enable-rise delta wipe lands one cycle after that. The bench therefore idles several cycles after every write or restart before it sends the next packet. It holds the cycle timer constant through each packet, so the model's timestamps do not depend on the acceptance cycle.

// File: rtl/iso_ts_pkg.sv
`timescale 1ns/1ps
package iso_ts_pkg;

    localparam int CNT_W        = 13;
    localparam int OFS_W        = 12;
    localparam int CNT_MOD      = 8000;
    localparam int OFS_MOD      = 3072;
    localparam int DV_EN_BIT    = 8;
    localparam int MPEG_EN_BIT  = 10;
    localparam int NO_DELTA_BIT = 31;
    localparam logic [1:0] TAG_CIP  = 2'b01;
    localparam logic [5:0] FMT_DV   = 6'h00;
    localparam logic [5:0] FMT_MPEG = 6'h20;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [OFS_W-1:0] ofs;
    } ts_t;

    typedef enum logic [1:0] {
        ST_HEAD,
        ST_CIP0,
        ST_CIP1,
        ST_BODY
    } walk_e;

    // Sum of two cycle-timer values: offset wraps at 3072 with carry, count wraps at 8000.
    function automatic ts_t ts_add(input ts_t a, input ts_t b);
        logic [OFS_W:0] s_ofs;
        logic [CNT_W:0] s_cnt;
        logic           carry;
        ts_t            r;
        s_ofs = {1'b0, a.ofs} + {1'b0, b.ofs};
        carry = (s_ofs >= (OFS_W+1)'(OFS_MOD));
        if (carry) s_ofs = s_ofs - (OFS_W+1)'(OFS_MOD);
        s_cnt = {1'b0, a.cnt} + {1'b0, b.cnt} + {{CNT_W{1'b0}}, carry};
        if (s_cnt >= (CNT_W+1)'(CNT_MOD)) s_cnt = s_cnt - (CNT_W+1)'(CNT_MOD);
        r.cnt = s_cnt[CNT_W-1:0];
        r.ofs = s_ofs[OFS_W-1:0];
        return r;
    endfunction

    // (a - b) mod 8000 for counts already in range.
    function automatic logic [CNT_W-1:0] cnt_sub(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
        logic [CNT_W:0] d;
        d = {1'b0, a} + (CNT_W+1)'(CNT_MOD) - {1'b0, b};
        if (d >= (CNT_W+1)'(CNT_MOD)) d = d - (CNT_W+1)'(CNT_MOD);
        return d[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/iso_ts_regs.sv
`timescale 1ns/1ps
module iso_ts_regs #(
    parameter int N_CTX    = 8,
    parameter int AW       = 4,
    parameter int DW       = 32,
    parameter int ADDR_SET = 0,
    parameter int ADDR_CLR = 1,
    parameter int OFS_BASE = 8,
    localparam int CTX_W   = $clog2(N_CTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic [CTX_W-1:0] rd_ctx,
    output logic [DW-1:0]    ctrl,
    output logic [DW-1:0]    ofs_sel
);

    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] ofs_q [N_CTX];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            for (int i = 0; i < N_CTX; i++) ofs_q[i] <= '0;
        end else if (reg_wr) begin
            if (reg_addr == AW'(ADDR_SET)) ctrl_q <= ctrl_q | reg_wdata;
            if (reg_addr == AW'(ADDR_CLR)) ctrl_q <= ctrl_q & ~reg_wdata;
            for (int i = 0; i < N_CTX; i++) begin
                if (reg_addr == AW'(OFS_BASE + i)) ofs_q[i] <= reg_wdata;
            end
        end
    end

    assign ctrl    = ctrl_q;
    assign ofs_sel = ofs_q[rd_ctx];

endmodule

// File: rtl/iso_ts_delta.sv
`timescale 1ns/1ps
module iso_ts_delta #(
    parameter int N_CTX  = 8,
    parameter int CNT_W  = 13,
    localparam int CTX_W = $clog2(N_CTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mpeg_en,
    input  logic             restart,
    input  logic [CTX_W-1:0] restart_ctx,
    input  logic             cap,
    input  logic [CTX_W-1:0] sel_ctx,
    input  logic [CNT_W-1:0] cap_value,
    output logic             sel_valid,
    output logic [CNT_W-1:0] sel_value
);

    logic             en_prev;
    logic [N_CTX-1:0] held_q;
    logic [CNT_W-1:0] delta_q [N_CTX];
    logic             wipe_all;

    assign wipe_all = mpeg_en && !en_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev <= 1'b0;
            held_q  <= '0;
            for (int i = 0; i < N_CTX; i++) delta_q[i] <= '0;
        end else begin
            en_prev <= mpeg_en;
            for (int i = 0; i < N_CTX; i++) begin
                if (wipe_all || (restart && restart_ctx == CTX_W'(i))) begin
                    held_q[i] <= 1'b0;
                end else if (cap && sel_ctx == CTX_W'(i)) begin
                    held_q[i]  <= 1'b1;
                    delta_q[i] <= cap_value;
                end
            end
        end
    end

    assign sel_valid = held_q[sel_ctx];
    assign sel_value = delta_q[sel_ctx];

endmodule

// File: rtl/iso_ts_walker.sv
`timescale 1ns/1ps
module iso_ts_walker
    import iso_ts_pkg::*;
#(
    parameter int N_CTX    = 8,
    parameter int DW       = 32,
    parameter int SP_WORDS = 48,
    localparam int CTX_W   = $clog2(N_CTX),
    localparam int IDX_W   = $clog2(SP_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cyc_count,
    input  logic [OFS_W-1:0] cyc_offset,
    input  logic             dv_en,
    input  logic             mpeg_en,
    input  logic [DW-1:0]    ofs_word,
    input  logic             d_valid,
    input  logic [CNT_W-1:0] d_value,
    output logic             cap,
    output logic [CNT_W-1:0] cap_value,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DW-1:0]    in_data,
    input  logic [CTX_W-1:0] in_ctx,
    input  logic             in_last,
    input  logic             in_frame,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DW-1:0]    out_data,
    output logic [CTX_W-1:0] out_ctx,
    output logic             out_last
);

    walk_e            st_q, st_d;
    logic             tag_ok_q;
    logic             frame_q;
    logic             mpeg_q;
    logic [IDX_W-1:0] idx_q;
    logic             take;
    logic [DW-1:0]    word_d;

    ts_t              bus_ts, user_ts, syt_ts, sph_ts, step_ts, new_ts, delta_ts;
    logic [5:0]       fmt;
    logic             dv_hit, sph_hit, use_delta;
    logic [CNT_W-1:0] delta_new, delta_now;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (take) begin
            unique case (st_q)
                ST_HEAD: st_d = ST_CIP0;
                ST_CIP0: st_d = ST_CIP1;
                ST_CIP1: st_d = ST_BODY;
                ST_BODY: st_d = ST_BODY;
            endcase
            if (in_last) st_d = ST_HEAD;
        end
    end

    // state register and per-packet context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_HEAD;
            tag_ok_q <= 1'b0;
            frame_q  <= 1'b0;
            mpeg_q   <= 1'b0;
            idx_q    <= '0;
        end else begin
            st_q <= st_d;
            if (take) begin
                unique case (st_q)
                    ST_HEAD: begin
                        tag_ok_q <= (in_data[15:14] == TAG_CIP);
                        frame_q  <= in_frame;
                        mpeg_q   <= 1'b0;
                    end
                    ST_CIP0: ;
                    ST_CIP1: begin
                        mpeg_q <= mpeg_en && tag_ok_q && (fmt == FMT_MPEG);
                        idx_q  <= '0;
                    end
                    ST_BODY: begin
                        idx_q <= (idx_q == IDX_W'(SP_WORDS - 1)) ? '0 : idx_q + 1'b1;
                    end
                endcase
            end
        end
    end

    // timestamp arithmetic
    assign bus_ts    = '{cnt: cyc_count, ofs: cyc_offset};
    assign user_ts   = ts_t'(ofs_word[CNT_W+OFS_W-1:0]);
    assign fmt       = in_data[29:24];
    assign syt_ts    = ts_add(bus_ts, user_ts);
    assign sph_ts    = ts_t'(in_data[CNT_W+OFS_W-1:0]);
    assign use_delta = !ofs_word[NO_DELTA_BIT];
    assign delta_new = cnt_sub(cyc_count, sph_ts.cnt);
    assign delta_now = d_valid ? d_value : delta_new;
    assign delta_ts  = '{cnt: (use_delta ? delta_now : '0), ofs: '0};
    assign step_ts   = ts_add(sph_ts, user_ts);
    assign new_ts    = ts_add(step_ts, delta_ts);

    assign dv_hit  = (st_q == ST_CIP1) && dv_en && tag_ok_q && frame_q && (fmt == FMT_DV);
    assign sph_hit = (st_q == ST_BODY) && mpeg_q && (idx_q == '0);

    assign cap       = take && sph_hit && use_delta && !d_valid;
    assign cap_value = delta_new;

    // output word
    always_comb begin
        word_d = in_data;
        unique case (st_q)
            ST_HEAD, ST_CIP0: ;
            ST_CIP1: if (dv_hit) word_d[15:0] = {syt_ts.cnt[3:0], syt_ts.ofs};
            ST_BODY: if (sph_hit) word_d[CNT_W+OFS_W-1:0] = new_ts;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ctx   <= '0;
            out_last  <= 1'b0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_data  <= word_d;
            out_ctx   <= in_ctx;
            out_last  <= in_last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/iso_ts_inserter.sv
`timescale 1ns/1ps
module iso_ts_inserter
    import iso_ts_pkg::*;
#(
    parameter int N_CTX    = 8,
    parameter int AW       = 4,
    parameter int DW       = 32,
    parameter int SP_WORDS = 48,
    parameter int ADDR_SET = 0,
    parameter int ADDR_CLR = 1,
    parameter int OFS_BASE = 8,
    localparam int CTX_W   = $clog2(N_CTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [12:0]      cyc_count,
    input  logic [11:0]      cyc_offset,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic             restart,
    input  logic [CTX_W-1:0] restart_ctx,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DW-1:0]    in_data,
    input  logic [CTX_W-1:0] in_ctx,
    input  logic             in_last,
    input  logic             in_frame,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DW-1:0]    out_data,
    output logic [CTX_W-1:0] out_ctx,
    output logic             out_last
);

    logic [DW-1:0]    ctrl_q;
    logic [DW-1:0]    ofs_sel;
    logic             d_valid;
    logic [CNT_W-1:0] d_value;
    logic             cap;
    logic [CNT_W-1:0] cap_value;

    iso_ts_regs #(
        .N_CTX(N_CTX), .AW(AW), .DW(DW),
        .ADDR_SET(ADDR_SET), .ADDR_CLR(ADDR_CLR), .OFS_BASE(OFS_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rd_ctx(in_ctx), .ctrl(ctrl_q), .ofs_sel(ofs_sel)
    );

    iso_ts_delta #(.N_CTX(N_CTX), .CNT_W(CNT_W)) u_delta (
        .clk(clk), .rst_n(rst_n),
        .mpeg_en(ctrl_q[MPEG_EN_BIT]),
        .restart(restart), .restart_ctx(restart_ctx),
        .cap(cap), .sel_ctx(in_ctx), .cap_value(cap_value),
        .sel_valid(d_valid), .sel_value(d_value)
    );

    iso_ts_walker #(.N_CTX(N_CTX), .DW(DW), .SP_WORDS(SP_WORDS)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .cyc_count(cyc_count), .cyc_offset(cyc_offset),
        .dv_en(ctrl_q[DV_EN_BIT]), .mpeg_en(ctrl_q[MPEG_EN_BIT]),
        .ofs_word(ofs_sel), .d_valid(d_valid), .d_value(d_value),
        .cap(cap), .cap_value(cap_value),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_ctx(in_ctx), .in_last(in_last), .in_frame(in_frame),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_ctx(out_ctx), .out_last(out_last)
    );

endmodule

// File: rtl/iso_ts_inserter_chk.sv
`timescale 1ns/1ps
module iso_ts_inserter_chk #(
    parameter int AW       = 4,
    parameter int DW       = 32,
    parameter int CTX_W    = 3,
    parameter int ADDR_SET = 0,
    parameter int ADDR_CLR = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [AW-1:0]    reg_addr,
    input logic [DW-1:0]    reg_wdata,
    input logic [DW-1:0]    ctrl_q,
    input logic             in_valid,
    input logic             in_ready,
    input logic [DW-1:0]    in_data,
    input logic [CTX_W-1:0] in_ctx,
    input logic             out_valid,
    input logic             out_ready,
    input logic [DW-1:0]    out_data,
    input logic [CTX_W-1:0] out_ctx
);

    assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == AW'(ADDR_SET) |=> (ctrl_q & $past(reg_wdata)) == $past(reg_wdata));

    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == AW'(ADDR_CLR) |=> (ctrl_q & $past(reg_wdata)) == '0);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && out_ctx == $past(in_ctx));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ctx));

    assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    assert_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_data[DW-1:25] == $past(in_data[DW-1:25]));

endmodule

bind iso_ts_inserter iso_ts_inserter_chk #(
    .AW(AW), .DW(DW), .CTX_W(CTX_W), .ADDR_SET(ADDR_SET), .ADDR_CLR(ADDR_CLR)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ctrl_q(ctrl_q),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_ctx(in_ctx),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ctx(out_ctx)
);

// File: tb/iso_ts_inserter_test.sv
`timescale 1ns/1ps
module iso_ts_inserter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] cyc_count = '0;
    logic [11:0] cyc_offset = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        restart = 1'b0;
    logic [2:0]  restart_ctx = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [2:0]  in_ctx = '0;
    logic        in_last = 1'b0;
    logic        in_frame = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [2:0]  out_ctx;
    logic        out_last;

    always #2 clk = ~clk;

    iso_ts_inserter uut (
        .clk(clk), .rst_n(rst_n), .cyc_count(cyc_count), .cyc_offset(cyc_offset),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .restart(restart), .restart_ctx(restart_ctx),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_ctx(in_ctx),
        .in_last(in_last), .in_frame(in_frame),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_ctx(out_ctx), .out_last(out_last)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       req_q[$];
    int          ctx_q[$];

    // behavioural model state
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_ofs [8];
    bit          m_held [8];
    int          m_delta [8];
    bit          bp = 1'b0;
    int          cyc_n = 0;
    bit          lat_pend = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic void tsadd(input int ac, input int ao, input int bc, input int bo,
                                  output int rc, output int ro);
        int o = ao + bo;
        int c = 0;
        if (o >= 3072) begin o -= 3072; c = 1; end
        ro = o;
        rc = (ac + bc + c) % 8000;
    endfunction

    always @(posedge clk) begin
        cyc_n <= cyc_n + 1;
        out_ready <= bp ? ((cyc_n % 3) != 0) : 1'b1;
    end

    // compare every transfer and every latency obligation
    always @(negedge clk) begin
        if (rst_n) begin
            if (lat_pend) check(out_valid === 1'b1, "R2 latency", {31'd0, out_valid}, 32'd1);
            lat_pend = in_valid && in_ready;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected word", out_data, 32'hx);
                end else begin
                    logic [31:0] e;
                    string r;
                    int c;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    c = ctx_q.pop_front();
                    check(out_data === e, r, out_data, e);
                    check(out_ctx === 3'(c), "R2 ctx", {29'd0, out_ctx}, c);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        if (a == 4'd0) begin
            if (!m_ctrl[10] && d[10]) for (int i = 0; i < 8; i++) m_held[i] = 1'b0;
            m_ctrl = m_ctrl | d;
        end else if (a == 4'd1) begin
            m_ctrl = m_ctrl & ~d;
        end else if (a >= 4'd8) begin
            m_ofs[a - 4'd8] = d;
        end
        idle(3);
    endtask

    task automatic do_restart(input int c);
        @(posedge clk); #1;
        restart = 1'b1; restart_ctx = 3'(c);
        @(posedge clk); #1;
        restart = 1'b0;
        m_held[c] = 1'b0;
        idle(2);
    endtask

    task automatic put(input logic [31:0] d, input int c, input bit last, input bit frame,
                       input logic [31:0] e, input string req);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = d; in_ctx = 3'(c); in_last = last; in_frame = frame;
        exp_q.push_back(e); req_q.push_back(req); ctx_q.push_back(c);
        while (!in_ready) begin @(posedge clk); #1; end
    endtask

    task automatic end_put();
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0; in_frame = 1'b0;
    endtask

    // one packet: header, two CIP quadlets, n_sp source packets of 48 words
    task automatic send_pkt(input int c, input logic [1:0] tag, input logic [5:0] fmt,
                            input bit frame, input int n_sp, input int ts_c, input int ts_o,
                            input string req);
        logic [31:0] w, e;
        bit dv, mp, nodelta;
        int rc, ro, uc, uo;
        uc = int'(m_ofs[c][24:12]);
        uo = int'(m_ofs[c][11:0]);
        nodelta = m_ofs[c][31];
        dv = m_ctrl[8] && tag == 2'b01 && fmt == 6'h00 && frame;
        mp = m_ctrl[10] && tag == 2'b01 && fmt == 6'h20;
        w = {16'd100, tag, 6'd7, 4'hA, 4'h0};
        put(w, c, 1'b0, frame, w, "R9 header");
        w = 32'h0044_0000 | 32'(c);
        put(w, c, 1'b0, 1'b0, w, "R9 cip0");
        w = {2'b10, fmt, 8'h80, 16'hBEEF};
        e = w;
        if (dv) begin
            tsadd(int'(cyc_count), int'(cyc_offset), uc, uo, rc, ro);
            e[15:0] = {4'(rc), 12'(ro)};
        end
        put(w, c, n_sp == 0, 1'b0, e, req);
        for (int s = 0; s < n_sp; s++) begin
            for (int k = 0; k < 48; k++) begin
                bit last = (s == n_sp - 1) && (k == 47);
                if (k == 0) begin
                    int tc = (ts_c + s) % 8000;
                    w = {7'h55, 13'(tc), 12'(ts_o)};
                    e = w;
                    if (mp) begin
                        int d = 0;
                        if (!nodelta) begin
                            if (!m_held[c]) begin
                                m_delta[c] = (int'(cyc_count) - tc + 8000) % 8000;
                                m_held[c] = 1'b1;
                            end
                            d = m_delta[c];
                        end
                        tsadd(tc, ts_o, uc, uo, rc, ro);
                        tsadd(rc, ro, d, 0, rc, ro);
                        e[24:0] = {13'(rc), 12'(ro)};
                    end
                    put(w, c, last, 1'b0, e, req);
                end else begin
                    w = {8'hC0, 8'(c), 8'(s), 8'(k)};
                    put(w, c, last, 1'b0, w, "R9 payload");
                end
            end
        end
        end_put();
    endtask

    // watchdog
    initial begin
        int n = 0;
        forever begin
            @(posedge clk);
            n++;
            if (n > 150000) begin
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_ofs[i] = '0; m_held[i] = 1'b0; m_delta[i] = 0; end
        idle(3);
        #1;
        check(out_valid === 1'b0, "R2 reset out_valid", {31'd0, out_valid}, 32'd0);
        check(in_ready === 1'b1, "R2 reset in_ready", {31'd0, in_ready}, 32'd1);
        rst_n = 1'b1;
        idle(2);

        // R10: distinct offsets per context
        wr(4'd9,  {7'd0, 13'd3, 12'd2000});
        wr(4'd10, {7'd0, 13'd5, 12'd100});
        wr(4'd11, {1'b1, 6'd0, 13'd2, 12'd50});
        wr(4'd12, {7'd0, 13'd4000, 12'd10});
        // R1: video disabled first
        cyc_count = 13'd7999; cyc_offset = 12'd1500;
        send_pkt(1, 2'b01, 6'h00, 1'b1, 0, 0, 0, "R4 dv disabled");
        wr(4'd0, 32'h0000_0500);

        // R3: carry into count and wrap at 8000
        send_pkt(1, 2'b01, 6'h00, 1'b1, 0, 0, 0, "R3 dv syt wrap");
        cyc_count = 13'd1234; cyc_offset = 12'd10;
        send_pkt(4, 2'b01, 6'h00, 1'b1, 0, 0, 0, "R10 dv ctx4 offset");
        send_pkt(1, 2'b01, 6'h00, 1'b0, 0, 0, 0, "R4 dv no frame");
        send_pkt(1, 2'b00, 6'h00, 1'b1, 0, 0, 0, "R4 dv wrong tag");

        // R5 R6: capture on first header, reuse later
        cyc_count = 13'd7990; cyc_offset = 12'd0;
        send_pkt(2, 2'b01, 6'h20, 1'b0, 2, 10, 3000, "R6 mpeg delta capture");
        cyc_count = 13'd200;
        send_pkt(2, 2'b01, 6'h20, 1'b0, 1, 50, 3071, "R6 mpeg delta reuse");
        send_pkt(2, 2'b01, 6'h21, 1'b0, 1, 50, 10, "R5 wrong fmt");
        send_pkt(2, 2'b00, 6'h20, 1'b0, 1, 50, 10, "R5 wrong tag");

        // R7: delta disabled on ctx3
        send_pkt(3, 2'b01, 6'h20, 1'b0, 1, 7999, 3000, "R7 no delta");
        send_pkt(3, 2'b01, 6'h20, 1'b0, 1, 100, 5, "R7 no delta again");

        // R8: restart recaptures
        do_restart(2);
        cyc_count = 13'd4000;
        send_pkt(2, 2'b01, 6'h20, 1'b0, 1, 30, 0, "R8 restart recapture");

        // R1 clear, then R8 enable rise wipe
        wr(4'd1, 32'h0000_0400);
        send_pkt(2, 2'b01, 6'h20, 1'b0, 1, 30, 0, "R1 mpeg cleared");
        send_pkt(1, 2'b01, 6'h00, 1'b1, 0, 0, 0, "R1 dv still set");
        cyc_count = 13'd6000;
        wr(4'd0, 32'h0000_0400);
        send_pkt(2, 2'b01, 6'h20, 1'b0, 1, 7000, 20, "R8 enable rise recapture");

        // R2: backpressure
        bp = 1'b1;
        send_pkt(2, 2'b01, 6'h20, 1'b0, 2, 123, 456, "R2 mpeg under stall");
        send_pkt(1, 2'b01, 6'h00, 1'b1, 0, 0, 0, "R2 dv under stall");
        bp = 1'b0;

        idle(20);
        check(exp_q.size() == 0, "R2 drained", 32'(exp_q.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule